// File: doc/BRIEF.md
# Frequency Foldback Boost Cycle Controller

This block is the digital cycle engine of a boost converter that runs in critical conduction at heavy line current and stretches its switching period at light current. It sees four comparator flags that are already synchronous to its clock: the auxiliary-winding zero-current flag, the current-limit flag, the overstress flag and an on-time-done flag from an external ramp. From these it drives a single gate-enable output. An 8-bit line-current code sets how long the block waits after the inductor has demagnetised before it turns the switch back on. The same code drives a hysteretic skip band that stops switching near the line zero crossing.

Each on-time is ended by the on-time flag or by either sense flag once its leading-edge blanking window has passed. During the off-time a new cycle starts on a qualified valley (the falling edge of a long-enough zero-current pulse) once the dead time has run out. It also starts when the zero-current flag stays silent after turn-off (restart watchdog) or stops toggling after it has moved (missing valley). The dead time is computed once per cycle, at the turn-off instant. Pulling the enable low drops the gate in the same cycle and returns every timer to idle.

Top module: `pfc_ff_ctrl`

## Requirements
- R1: After reset, and in any cycle where `en` is low, `gate` is 0. Dropping `en` clears `gate` without waiting for a clock edge. While `en` is low, all timers and the stored dead time return to zero.
- R2: A cycle in which `gate` is 1 and `ton_done` is 1 ends the on-time, so `gate` is 0 in the next cycle.
- R3: `ilim` is ignored in the first LEB_ILIM_CYC cycles of an on-time (default 10, 200 ns at 50 MHz). After that window it ends the on-time at the next edge, so `ilim` held high from turn-on gives a gate pulse of exactly LEB_ILIM_CYC+1 cycles.
- R4: `ovs` behaves the same way with its own window of LEB_OVS_CYC cycles (default 5, 100 ns). If held high from turn-on it gives a pulse of LEB_OVS_CYC+1 cycles.
- R5: A `level` code of 128 or more (code 255 = 5 V, 128 = the 2.5 V reference) gives zero dead time. The gate then rises one cycle after the first sample of `zcd` low that follows a high run.
- R6: A `level` below 128 gives a dead time of floor(DT_BASE_CYC × (128 − level) / 128) cycles, using the `level` sampled in the turn-off cycle. Valleys that arrive before that many off cycles have passed are skipped, and the next valley after the dead time starts the cycle.
- R7: With `dt_long` = 1 in the turn-off cycle, DT_LONG_CYC (default 1900, 38 µs) replaces DT_BASE_CYC (default 650, 13 µs) in the R6 formula.
- R8: A `zcd` high run of fewer than ZCD_MIN_CYC consecutive samples (default 6) is not a valley.
- R9: If `zcd` does not change at all after turn-off, a new cycle starts in the off cycle whose count since turn-off reaches WDOG_CYC (default 10000, 200 µs). The gate is then low for WDOG_CYC+1 cycles.
- R10: Once `zcd` has changed during the off-time, VALLEY_TOUT_CYC quiet cycles (default 1500, 30 µs) after its last change start a new cycle, provided the dead time has elapsed.
- R11: `skip` rises the cycle after `level` is below SKIP_ENTER (33, about 0.65 V). It falls the cycle after `level` is above SKIP_LEAVE (38, about 0.75 V), and holds its value in between. While `skip` is 1 no new on-time starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (50 MHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low forces gate low and idles timers |
| zcd | input | 1 | Zero-current flag, high while the auxiliary winding is above threshold |
| ilim | input | 1 | Current-limit comparator flag |
| ovs | input | 1 | Overstress comparator flag |
| ton_done | input | 1 | On-time ramp has reached the control level |
| level | input | 8 | Line-current code, 255 = 5 V, 128 = reference |
| dt_long | input | 1 | Selects the long maximum dead time |
| gate | output | 1 | Gate-drive enable |
| skip | output | 1 | Skip band active |

## Verification
The bench works the blanking edges: a design that counts the window one cycle short or long gives an ilim or overstress pulse of the wrong width. It aims valleys just before and just after the end of the dead time, at the reference code and below it, and with the long maximum. A wrong multiplier or a dead time taken at the wrong moment would start on the wrong valley. Zero-current pulses shorter than the minimum width and a completely silent flag separate the missing-valley timeout from the watchdog; treating a glitch as a valley would restart far too early. Level steps inside the skip band and across both thresholds expose a comparator without hysteresis, which would chatter or release early.

// File: rtl/pfc_ff_pkg.sv
// Shared types of the foldback cycle controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pfc_ff_pkg;
    // Switch phase of the boost cycle.
    typedef enum logic {
        PH_OFF = 1'b0,
        PH_ON  = 1'b1
    } pfc_phase_e;
endpackage

// File: rtl/pfc_zcd_qual.sv
// Zero-current flag qualifier.
// Counts how long the flag has been high and reports a valley on the falling
// edge only when the high run was at least ZCD_MIN_CYC samples. It also
// reports any change of the flag, which drives the missing-valley timer.
// Assumes: zcd is already synchronous to clk.
module pfc_zcd_qual #(
    parameter int ZCD_MIN_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic zcd,
    output logic valley,
    output logic toggled
);
    localparam int HI_W = $clog2(ZCD_MIN_CYC + 1);
    localparam logic [HI_W-1:0] HI_MAX = HI_W'(ZCD_MIN_CYC);

    logic            zcd_prev;
    logic [HI_W-1:0] hi_cnt;

    // Track previous flag value and the saturating length of the high run.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            zcd_prev <= 1'b0;
            hi_cnt   <= '0;
        end else begin
            zcd_prev <= zcd;
            if (!zcd)
                hi_cnt <= '0;
            else if (hi_cnt != HI_MAX)
                hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // Valley is a falling edge after a long enough high run.
    always_comb begin
        valley  = zcd_prev & ~zcd & (hi_cnt >= HI_MAX);
        toggled = zcd_prev ^ zcd;
    end
endmodule

// File: rtl/pfc_leb.sv
// On-time counter with leading-edge blanking.
// One blanking window per sense channel (0: current limit, 1: overstress),
// built in a generate loop. A window of zero leaves that channel unblanked.
// The stop request also includes the on-time-done flag.
// Assumes: both windows fit the shared counter width.
module pfc_leb #(
    parameter int LEB_ILIM_CYC = 10,
    parameter int LEB_OVS_CYC  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic gate_on,
    input  logic ilim,
    input  logic ovs,
    input  logic ton_done,
    output logic stop
);
    localparam int NCH    = 2;
    localparam int ON_MAX = (LEB_ILIM_CYC > LEB_OVS_CYC) ? LEB_ILIM_CYC : LEB_OVS_CYC;
    localparam int CNT_W  = $clog2(ON_MAX + 2);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(ON_MAX);

    function automatic int blank_of(input int ch);
        return (ch == 0) ? LEB_ILIM_CYC : LEB_OVS_CYC;
    endfunction

    logic [CNT_W-1:0] on_cnt;
    logic [NCH-1:0]   sense;
    logic [NCH-1:0]   armed;

    assign sense = {ovs, ilim};

    // Count cycles since turn-on, saturating past the longest window.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !gate_on)
            on_cnt <= '0;
        else if (on_cnt != CNT_SAT)
            on_cnt <= on_cnt + 1'b1;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (blank_of(i) == 0) begin : g_open
            assign armed[i] = sense[i];
        end else begin : g_blank
            assign armed[i] = sense[i] & (on_cnt >= CNT_W'(blank_of(i)));
        end
    end

    // End the on-time on the done flag or on any unblanked sense flag.
    always_comb begin
        stop = gate_on & (ton_done | (|armed));
    end
endmodule

// File: rtl/pfc_foldback.sv
// Frequency foldback arithmetic and skip comparator.
// Latches the dead time DT_SEL*(REF-level)/REF at turn-off, zero at or above
// REF, with the divide done as a shift. Holds the hysteretic skip flag.
// Assumes: REF = 2**LVL_REF_LOG2 fits in LVL_W bits plus one.
module pfc_foldback #(
    parameter int LVL_W        = 8,
    parameter int LVL_REF_LOG2 = 7,
    parameter int DT_BASE_CYC  = 650,
    parameter int DT_LONG_CYC  = 1900,
    parameter int SKIP_ENTER   = 33,
    parameter int SKIP_LEAVE   = 38,
    parameter int DT_W         = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LVL_W-1:0] level,
    input  logic             dt_long,
    input  logic             latch,
    output logic             skip,
    output logic [DT_W-1:0]  dt_cyc
);
    localparam int PW = DT_W + LVL_W + 1;
    localparam logic [LVL_W:0] REF_CODE = (LVL_W + 1)'(1 << LVL_REF_LOG2);

    logic [LVL_W:0]  lvl_gap;
    logic [DT_W-1:0] dt_sel;
    logic [PW-1:0]   prod;
    logic [DT_W-1:0] dt_next;

    // Dead time candidate from the present level code.
    always_comb begin
        dt_sel  = dt_long ? DT_W'(DT_LONG_CYC) : DT_W'(DT_BASE_CYC);
        lvl_gap = ({1'b0, level} >= REF_CODE) ? '0 : (REF_CODE - {1'b0, level});
        prod    = {{(LVL_W + 1){1'b0}}, dt_sel} * {{DT_W{1'b0}}, lvl_gap};
        dt_next = prod[LVL_REF_LOG2 +: DT_W];
    end

    // Capture the dead time once per cycle, at the turn-off decision.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            dt_cyc <= '0;
        else if (latch)
            dt_cyc <= dt_next;
    end

    // Hysteretic skip band near the line zero crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            skip <= 1'b0;
        else if (level < LVL_W'(SKIP_ENTER))
            skip <= 1'b1;
        else if (level > LVL_W'(SKIP_LEAVE))
            skip <= 1'b0;
    end
endmodule

// File: rtl/pfc_ff_ctrl.sv
// Foldback boost cycle controller, top level.
// Holds the switch phase and the off-time timers (time since turn-off,
// zero-current activity flag, quiet time since the last change) and decides
// the next turn-on from valley, restart watchdog or missing-valley timeout.
// Assumes: all flags synchronous to clk; WDOG_CYC exceeds both dead-time
// maxima so the off counter can hold any dead time.
module pfc_ff_ctrl #(
    parameter int LVL_W           = 8,
    parameter int LVL_REF_LOG2    = 7,
    parameter int LEB_ILIM_CYC    = 10,
    parameter int LEB_OVS_CYC     = 5,
    parameter int ZCD_MIN_CYC     = 6,
    parameter int WDOG_CYC        = 10000,
    parameter int VALLEY_TOUT_CYC = 1500,
    parameter int DT_BASE_CYC     = 650,
    parameter int DT_LONG_CYC     = 1900,
    parameter int SKIP_ENTER      = 33,
    parameter int SKIP_LEAVE      = 38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             zcd,
    input  logic             ilim,
    input  logic             ovs,
    input  logic             ton_done,
    input  logic [LVL_W-1:0] level,
    input  logic             dt_long,
    output logic             gate,
    output logic             skip
);
    import pfc_ff_pkg::*;

    localparam int DT_MAX = (DT_LONG_CYC > DT_BASE_CYC) ? DT_LONG_CYC : DT_BASE_CYC;
    localparam int DT_W   = $clog2(DT_MAX + 1);
    localparam int OFF_W  = $clog2(WDOG_CYC + 1);
    localparam int QT_W   = $clog2(VALLEY_TOUT_CYC + 1);
    localparam logic [OFF_W-1:0] OFF_SAT = OFF_W'(WDOG_CYC);
    localparam logic [QT_W-1:0]  QT_SAT  = QT_W'(VALLEY_TOUT_CYC);

    pfc_phase_e      phase;
    logic            gate_on;
    logic            stop;
    logic            valley;
    logic            toggled;
    logic [DT_W-1:0] dt_cyc;
    logic [OFF_W-1:0] off_cnt;
    logic [QT_W-1:0]  quiet_cnt;
    logic            zcd_seen;
    logic            dt_ok;
    logic            wdog_fire;
    logic            tout_fire;
    logic            start;

    assign gate_on = (phase == PH_ON);

    pfc_zcd_qual #(
        .ZCD_MIN_CYC(ZCD_MIN_CYC)
    ) u_zcd (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .zcd    (zcd),
        .valley (valley),
        .toggled(toggled)
    );

    pfc_leb #(
        .LEB_ILIM_CYC(LEB_ILIM_CYC),
        .LEB_OVS_CYC (LEB_OVS_CYC)
    ) u_leb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .gate_on (gate_on),
        .ilim    (ilim),
        .ovs     (ovs),
        .ton_done(ton_done),
        .stop    (stop)
    );

    pfc_foldback #(
        .LVL_W       (LVL_W),
        .LVL_REF_LOG2(LVL_REF_LOG2),
        .DT_BASE_CYC (DT_BASE_CYC),
        .DT_LONG_CYC (DT_LONG_CYC),
        .SKIP_ENTER  (SKIP_ENTER),
        .SKIP_LEAVE  (SKIP_LEAVE),
        .DT_W        (DT_W)
    ) u_fold (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .level  (level),
        .dt_long(dt_long),
        .latch  (stop & en),
        .skip   (skip),
        .dt_cyc (dt_cyc)
    );

    // Turn-on decision from the off-time conditions.
    always_comb begin
        dt_ok     = (off_cnt >= OFF_W'(dt_cyc));
        wdog_fire = ~zcd_seen & (off_cnt >= OFF_SAT);
        tout_fire = zcd_seen & (quiet_cnt >= QT_SAT) & dt_ok;
        start     = ~gate_on & en & ~skip & ((valley & dt_ok) | wdog_fire | tout_fire);
    end

    // Off-time timers: time since turn-off, activity flag, quiet time.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || gate_on) begin
            off_cnt   <= '0;
            quiet_cnt <= '0;
            zcd_seen  <= 1'b0;
        end else begin
            if (off_cnt != OFF_SAT)
                off_cnt <= off_cnt + 1'b1;
            if (toggled) begin
                zcd_seen  <= 1'b1;
                quiet_cnt <= '0;
            end else if (quiet_cnt != QT_SAT) begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end
    end

    // Switch phase register.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            phase <= PH_OFF;
        else if (gate_on && stop)
            phase <= PH_OFF;
        else if (start)
            phase <= PH_ON;
    end

    // Gate enable, cut at once by the run enable.
    always_comb begin
        gate = gate_on & en;
    end
endmodule

// File: rtl/pfc_ff_ctrl_chk.sv
// Port-level checker for the foldback cycle controller, bound to the top.
// Assumes: synchronous active-low reset.
module pfc_ff_ctrl_chk #(
    parameter int LVL_W      = 8,
    parameter int SKIP_ENTER = 33,
    parameter int SKIP_LEAVE = 38
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ton_done,
    input logic             gate,
    input logic             skip,
    input logic [LVL_W-1:0] level
);
    // R1
    idle_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !gate);

    // R2
    ton_done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && ton_done) |=> !gate);

    // R3 R4: both sense flags are blanked in the first on cycle
    first_on_cycle_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate) && !ton_done) |=> (gate || !en));

    // R11
    skip_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level < LVL_W'(SKIP_ENTER)) |=> skip);

    // R11
    skip_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level > LVL_W'(SKIP_LEAVE)) |=> !skip);

    // R11
    skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= LVL_W'(SKIP_ENTER) && level <= LVL_W'(SKIP_LEAVE)) |=> $stable(skip));

    // R11
    no_start_in_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skip && !gate) |=> !gate);
endmodule

bind pfc_ff_ctrl pfc_ff_ctrl_chk #(
    .LVL_W     (LVL_W),
    .SKIP_ENTER(SKIP_ENTER),
    .SKIP_LEAVE(SKIP_LEAVE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .ton_done(ton_done),
    .gate    (gate),
    .skip    (skip),
    .level   (level)
);

// File: tb/pfc_ff_ctrl_bench.sv
// Bench: behavioural cycle model compared every clock, plus directed
// measurements of pulse and gap widths computed from the requirements.
module pfc_ff_ctrl_bench;
    localparam int CLK_PERIOD = 20;
    localparam int LI   = 10;
    localparam int LO   = 5;
    localparam int ZMIN = 6;
    localparam int WD   = 600;
    localparam int TO   = 120;
    localparam int DTB  = 200;
    localparam int DTL  = 500;
    localparam int SKE  = 33;
    localparam int SKL  = 38;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       zcd = 1'b0;
    logic       ilim = 1'b0;
    logic       ovs = 1'b0;
    logic       ton_done = 1'b0;
    logic [7:0] level = 8'd200;
    logic       dt_long = 1'b0;
    logic       gate;
    logic       skip;

    pfc_ff_ctrl #(
        .LEB_ILIM_CYC(LI), .LEB_OVS_CYC(LO), .ZCD_MIN_CYC(ZMIN),
        .WDOG_CYC(WD), .VALLEY_TOUT_CYC(TO), .DT_BASE_CYC(DTB),
        .DT_LONG_CYC(DTL), .SKIP_ENTER(SKE), .SKIP_LEAVE(SKL)
    ) u_pfc_ff_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .zcd(zcd), .ilim(ilim), .ovs(ovs),
        .ton_done(ton_done), .level(level), .dt_long(dt_long),
        .gate(gate), .skip(skip)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Stimulus configuration of the converter emulation.
    int ton_len  = 20;
    int ilim_at  = 100000;
    int ovs_at   = 100000;
    bit zcd_on   = 1'b1;
    int demag    = 20;
    int ring_w   = 0;
    int ring_gap = 8;
    int ring_n   = 0;

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit zcd_shape(input int t);
        int d, u, p;
        if (!zcd_on) return 1'b0;
        d = t - 3;
        if (d < 0) return 1'b0;
        if (d < demag) return 1'b1;
        u = d - demag;
        p = ring_gap + ring_w;
        if (ring_w == 0) return 1'b0;
        return ((u / p) < ring_n) && ((u % p) >= ring_gap);
    endfunction

    // Converter emulation: on-time flags and auxiliary winding shape.
    initial begin
        int hc, t;
        hc = 0;
        t = 0;
        forever begin
            @(posedge clk);
            #1;
            if (gate) begin
                hc++;
                t = 0;
                zcd = 1'b0;
            end else begin
                hc = 0;
                t++;
                zcd = zcd_shape(t);
            end
            ton_done = gate && (hc >= ton_len);
            ilim     = gate && (hc >= ilim_at);
            ovs      = gate && (hc >= ovs_at);
        end
    end

    // Reference model state.
    bit m_gate, m_skip, m_zprev, m_seen;
    int m_on, m_off, m_quiet, m_dt, m_hi;

    // Cycle model built from the requirements.
    initial begin
        bit valley, tr, st, nskip;
        int dsel;
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                m_gate = 0; m_skip = 0; m_zprev = 0; m_seen = 0;
                m_on = 0; m_off = 0; m_quiet = 0; m_dt = 0; m_hi = 0;
            end else begin
                nskip = (level < SKE) ? 1'b1 : (level > SKL) ? 1'b0 : m_skip;
                if (!en) begin
                    m_gate = 0; m_on = 0; m_off = 0; m_seen = 0; m_quiet = 0;
                    m_dt = 0; m_zprev = 0; m_hi = 0;
                end else begin
                    valley = m_zprev && !zcd && (m_hi >= ZMIN);
                    tr     = (m_zprev != zcd);
                    if (m_gate) begin
                        if (ton_done || (ilim && m_on >= LI) || (ovs && m_on >= LO)) begin
                            m_gate = 0;
                            dsel = dt_long ? DTL : DTB;
                            m_dt = (level >= 128) ? 0 : (dsel * (128 - int'(level))) / 128;
                        end
                        m_on++;
                        m_off = 0; m_seen = 0; m_quiet = 0;
                    end else begin
                        st = !m_skip && ((valley && m_off >= m_dt) ||
                                         (!m_seen && m_off >= WD) ||
                                         (m_seen && m_quiet >= TO && m_off >= m_dt));
                        m_on = 0;
                        m_off++;
                        if (tr) begin m_seen = 1; m_quiet = 0; end
                        else m_quiet++;
                        if (st) m_gate = 1;
                    end
                    m_hi = zcd ? m_hi + 1 : 0;
                    m_zprev = zcd;
                end
                m_skip = nskip;
            end
        end
    end

    // Compare outputs with the model away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (rst_n) begin
                check({cur_req, " gate"}, gate == (m_gate && en), gate, m_gate && en);
                check({cur_req, " skip"}, skip == m_skip, skip, m_skip);
            end
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Length of the next complete high run of the gate.
    task automatic high_len(output int n);
        n = 0;
        @(negedge clk);
        while (gate) @(negedge clk);
        while (!gate) @(negedge clk);
        while (gate) begin n++; @(negedge clk); end
    endtask

    // Length of the next complete low run of the gate.
    task automatic low_len(output int n);
        n = 0;
        @(negedge clk);
        while (!gate) @(negedge clk);
        while (gate) @(negedge clk);
        while (!gate) begin n++; @(negedge clk); end
    endtask

    task automatic set_in(input int lv, input bit lng);
        @(posedge clk);
        #1;
        level = 8'(lv);
        dt_long = lng;
    endtask

    initial begin
        int n, hits;
        wait_cyc(3);
        check("R1 reset gate", gate == 0, gate, 0);
        check("R1 reset skip", skip == 0, skip, 0);
        @(posedge clk); #1; rst_n = 1'b1; en = 1'b1;

        // R5: critical conduction at and above the reference code
        cur_req = "R5";
        set_in(200, 0);
        low_len(n); low_len(n);
        check("R5 crm gap", n == 3 + demag, n, 3 + demag);
        set_in(128, 0);
        low_len(n); low_len(n);
        check("R5 reference code gap", n == 3 + demag, n, 3 + demag);

        // R2: on-time flag width
        cur_req = "R2";
        high_len(n);
        check("R2 on width", n == ton_len, n, ton_len);

        // R3 and R4: blanking windows
        cur_req = "R3";
        @(posedge clk); #1; ilim_at = 1;
        high_len(n); high_len(n);
        check("R3 ilim pulse", n == LI + 1, n, LI + 1);
        cur_req = "R4";
        @(posedge clk); #1; ilim_at = 100000; ovs_at = 1;
        high_len(n); high_len(n);
        check("R4 ovs pulse", n == LO + 1, n, LO + 1);
        @(posedge clk); #1; ovs_at = 100000;

        // R6: dead time skips early valleys
        cur_req = "R6";
        @(posedge clk); #1; demag = 10; ring_w = 8; ring_gap = 8; ring_n = 100;
        set_in(64, 0);
        low_len(n); low_len(n);
        check("R6 gap after dead time", n > 100 && n <= 118, n, 101);
        set_in(127, 0);
        low_len(n); low_len(n);
        check("R6 tiny dead time", n == 3 + demag, n, 3 + demag);

        // R7: long maximum
        cur_req = "R7";
        set_in(64, 1);
        low_len(n); low_len(n);
        check("R7 long dead time", n > 250 && n <= 268, n, 251);
        set_in(200, 0);

        // R8 and R10: short pulses then silence trigger the timeout
        cur_req = "R10";
        @(posedge clk); #1; demag = ZMIN - 1; ring_n = 0;
        low_len(n); low_len(n);
        check("R8 short pulse ignored", n > TO, n, TO + 1);
        check("R10 timeout before watchdog", n < WD, n, TO + 3 + demag);

        // R9: silent flag, restart watchdog
        cur_req = "R9";
        @(posedge clk); #1; zcd_on = 1'b0;
        low_len(n); low_len(n);
        check("R9 watchdog gap", n == WD + 1, n, WD + 1);
        @(posedge clk); #1; zcd_on = 1'b1; demag = 20;

        // R11: skip hysteresis and suppression
        cur_req = "R11";
        set_in(20, 0);
        wait_cyc(2);
        check("R11 skip set", skip == 1, skip, 1);
        wait_cyc(30);
        hits = 0;
        for (int i = 0; i < WD + 50; i++) begin
            @(negedge clk);
            if (gate) hits++;
        end
        check("R11 no switching in skip", hits == 0, hits, 0);
        set_in(36, 0);
        wait_cyc(3);
        check("R11 skip held in band", skip == 1, skip, 1);
        set_in(40, 0);
        wait_cyc(2);
        check("R11 skip cleared", skip == 0, skip, 0);
        hits = 0;
        for (int i = 0; i < WD + 50; i++) begin
            @(negedge clk);
            if (gate) hits++;
        end
        check("R11 switching resumes", hits > 0, hits, 1);

        // R1: disable cuts the gate at once
        cur_req = "R1";
        set_in(200, 0);
        @(negedge clk);
        while (!gate) @(negedge clk);
        #1; en = 1'b0;
        #1;
        check("R1 immediate cut", gate == 0, gate, 0);
        hits = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (gate) hits++;
        end
        check("R1 held off", hits == 0, hits, 0);
        @(posedge clk); #1; en = 1'b1;
        wait_cyc(WD + 100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule